// File: doc/BRIEF.md
# Camera Pixel Container Packer

This block takes a camera byte stream whose packet headers have already been removed and turns it into 128-bit words for a DMA engine. A 6-bit data-type code tells the block how to group the incoming bytes into pixels. A 2-bit container code then sets the width of the memory slot that each pixel occupies: 8, 16 or 32 bits. Containers are packed into the output word little-endian, so the earliest pixel sits in the lowest bits. For 8-bit YUV 4:2:2 data, a 2-bit swap mode can reorder the four bytes of each chroma/luma group before they are stored.

Both stream interfaces use valid/ready. A byte moves on the input on any rising edge where `in_valid` and `in_ready` are both high. A word moves on the output on any rising edge where `out_valid` and `out_ready` are both high. While a word is offered but not taken, the block holds the word and all its flags steady. It takes no further container into that word, and the stall reaches `in_ready` within a few cycles.

The byte that ends a line is marked with `in_eol`. The output word that holds the last pixel of the line carries `out_eol`. A line is expected to fill a whole number of words. If it does not, the last word is padded with zeros. The configuration inputs are plain levels. `cfg_pix_run` releases the pixel path from reset, and `cfg_enable` gates the input.

Top module: `cam_pixpack`

## Requirements
- R1: While `cfg_pix_run` is 0, the pixel path is held in reset. `in_ready` and `out_valid` are 0, and any partly assembled pixel group or word is discarded. Setting `cfg_pix_run` to 1 releases the path.
- R2: While `cfg_enable` is 0, `in_ready` is 0 and no byte is accepted.
- R3: Container code 0 gives 8-bit containers (16 per word). Code 1 gives 16-bit containers (8 per word). Code 2 gives 32-bit containers (4 per word). Code 3 behaves like code 2.
- R4: Container i of a word occupies bits [i*W+W-1 : i*W], where W is the container width. The earliest pixel goes in container 0. Container bits above the pixel's width are 0. A pixel wider than its container keeps only its low W bits.
- R5: Data type 0x2A (RAW8), and any code not listed in R6 to R9, takes one byte per pixel.
- R6: Data type 0x2B (RAW10) takes 5 bytes per 4 pixels. Pixel k (k = 0 to 3) is {byte k, bits [2k+1:2k] of byte 4}, which gives a 10-bit value.
- R7: Data type 0x22 (RGB565) takes 2 bytes per pixel. The first byte is the low byte.
- R8: Data type 0x24 (RGB888) takes 3 bytes per pixel. The first byte is the lowest, and bits 31:24 are 0.
- R9: Data type 0x1E (YUV422 8-bit) reads 4-byte groups that arrive as U0, Y0, V0, Y1. Each group is stored in four 8-bit-or-wider containers, listed from the lowest container up, according to `cfg_yuv_mode`:
  - mode 3: U0, Y0, V0, Y1
  - mode 2: V0, Y0, U0, Y1
  - mode 1: Y0, U0, Y1, V0
  - mode 0: Y0, V0, Y1, U0
- R10: `cfg_yuv_mode` has no effect for any data type other than 0x1E.
- R11: The word that holds a line's last pixel is sent with `out_eol`=1, and every other word with `out_eol`=0. A partial final word is zero-padded. If `in_eol` arrives in the middle of a pixel group, the missing bytes are treated as 0 and the group still yields its full pixel count.
- R12: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_eol` hold their values, and no byte or pixel is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_pix_run | input | 1 | 1 releases the pixel path; 0 holds it in reset |
| cfg_enable | input | 1 | Input gate |
| cfg_dtype | input | 6 | Data-type code |
| cfg_csize | input | 2 | Container width code |
| cfg_yuv_mode | input | 2 | YUV422 byte order mode |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted |
| in_data | input | 8 | Input byte |
| in_eol | input | 1 | Byte is the last of a line |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Consumer accepts word |
| out_data | output | 128 | Packed output word |
| out_eol | output | 1 | Word ends a line |

## Verification
The assertions assume that `cfg_dtype`, `cfg_csize` and `cfg_yuv_mode` stay fixed while a line is in flight. This matters most for the zero-fill properties, which decode the word on the output port using the current configuration. The bench changes the configuration only after the previous line's last word has been taken and the path is idle, or while `cfg_pix_run` is low. The hold property assumes a consumer that may drop `out_ready` at any point. The bench therefore drives `out_ready` and `in_valid` with irregular patterns on selected vectors.

// File: rtl/cam_pixpack_pkg.sv
package cam_pixpack_pkg;

  localparam int BYTE_W  = 8;
  localparam int PIX_W   = 32;
  localparam int GRP_MAX = 5;
  localparam int GRP_W   = GRP_MAX * BYTE_W;

  localparam logic [5:0] DT_YUV8   = 6'h1E;
  localparam logic [5:0] DT_RGB565 = 6'h22;
  localparam logic [5:0] DT_RGB888 = 6'h24;
  localparam logic [5:0] DT_RAW8   = 6'h2A;
  localparam logic [5:0] DT_RAW10  = 6'h2B;

  // bytes consumed per pixel group
  function automatic logic [2:0] grp_bytes(input logic [5:0] dt);
    case (dt)
      DT_YUV8:   return 3'd4;
      DT_RGB565: return 3'd2;
      DT_RGB888: return 3'd3;
      DT_RAW10:  return 3'd5;
      default:   return 3'd1;
    endcase
  endfunction

  // containers emitted per pixel group
  function automatic logic [2:0] grp_pixels(input logic [5:0] dt);
    case (dt)
      DT_YUV8, DT_RAW10: return 3'd4;
      default:           return 3'd1;
    endcase
  endfunction

  // which arrival byte (0=U0,1=Y0,2=V0,3=Y1) lands in output slot k
  function automatic logic [1:0] yuv_src(input logic [1:0] mode, input logic [1:0] k);
    logic [7:0] map;
    case (mode)
      2'd3:    map = {2'd3, 2'd2, 2'd1, 2'd0};
      2'd2:    map = {2'd3, 2'd0, 2'd1, 2'd2};
      2'd1:    map = {2'd2, 2'd3, 2'd0, 2'd1};
      default: map = {2'd0, 2'd3, 2'd2, 2'd1};
    endcase
    return map[k*2 +: 2];
  endfunction

  function automatic logic [PIX_W-1:0] grp_pixel(input logic [5:0] dt,
                                                 input logic [1:0] mode,
                                                 input logic [GRP_W-1:0] g,
                                                 input logic [1:0] k);
    logic [1:0] s;
    s = yuv_src(mode, k);
    case (dt)
      DT_YUV8:   return {24'd0, g[s*BYTE_W +: BYTE_W]};
      DT_RAW10:  return {22'd0, g[k*BYTE_W +: BYTE_W], g[4*BYTE_W + 2*k +: 2]};
      DT_RGB565: return {16'd0, g[15:0]};
      DT_RGB888: return {8'd0, g[23:0]};
      default:   return {24'd0, g[7:0]};
    endcase
  endfunction

endpackage

// File: rtl/cam_unpack.sv
module cam_unpack
  import cam_pixpack_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             en,
  input  logic [5:0]       dt,
  input  logic [1:0]       mode,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [BYTE_W-1:0] in_data,
  input  logic             in_eol,
  output logic             pc_valid,
  input  logic             pc_ready,
  output logic [PIX_W-1:0] pc_data,
  output logic             pc_eol
);

  logic [GRP_W-1:0] grp;
  logic [2:0]       bcnt;
  logic [1:0]       ecnt;
  logic             emitting;
  logic             eol_q;
  logic [2:0]       glen;
  logic [2:0]       npix;
  logic             last_pix;

  assign glen     = grp_bytes(dt);
  assign npix     = grp_pixels(dt);
  assign last_pix = ({1'b0, ecnt} == 3'(npix - 3'd1));

  assign in_ready = run && en && !emitting;
  assign pc_valid = emitting;
  assign pc_data  = grp_pixel(dt, mode, grp, ecnt);
  assign pc_eol   = eol_q && last_pix;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp      <= '0;
      bcnt     <= '0;
      ecnt     <= '0;
      emitting <= 1'b0;
      eol_q    <= 1'b0;
    end else if (!run) begin
      grp      <= '0;
      bcnt     <= '0;
      ecnt     <= '0;
      emitting <= 1'b0;
      eol_q    <= 1'b0;
    end else if (!emitting) begin
      if (in_valid && in_ready) begin
        grp[bcnt*BYTE_W +: BYTE_W] <= in_data;
        if (3'(bcnt + 3'd1) == glen || in_eol) begin
          emitting <= 1'b1;
          ecnt     <= '0;
          eol_q    <= in_eol;
          bcnt     <= '0;
        end else begin
          bcnt <= bcnt + 3'd1;
        end
      end
    end else if (pc_ready) begin
      if (last_pix) begin
        emitting <= 1'b0;
        grp      <= '0;
        eol_q    <= 1'b0;
      end else begin
        ecnt <= ecnt + 2'd1;
      end
    end
  end

endmodule

// File: rtl/cam_pack.sv
module cam_pack
  import cam_pixpack_pkg::*;
#(
  parameter int WORD_W = 128
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [1:0]        csize,
  input  logic              pc_valid,
  output logic              pc_ready,
  input  logic [PIX_W-1:0]  pc_data,
  input  logic              pc_eol,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              out_eol
);

  localparam int SLOTS_MAX = WORD_W / 8;
  localparam int SLOT_W    = $clog2(SLOTS_MAX);
  localparam int SH_W      = $clog2(WORD_W);
  localparam int LAST8     = WORD_W / 8 - 1;
  localparam int LAST16    = WORD_W / 16 - 1;
  localparam int LAST32    = WORD_W / 32 - 1;

  logic [WORD_W-1:0] acc;
  logic [WORD_W-1:0] merged;
  logic [SLOT_W-1:0] slot;
  logic [PIX_W-1:0]  val;
  logic [SH_W-1:0]   shamt;
  logic              last;

  always_comb begin
    case (csize)
      2'd0: begin
        val   = {24'd0, pc_data[7:0]};
        shamt = SH_W'(int'(slot) * 8);
        last  = (int'(slot) == LAST8);
      end
      2'd1: begin
        val   = {16'd0, pc_data[15:0]};
        shamt = SH_W'(int'(slot) * 16);
        last  = (int'(slot) == LAST16);
      end
      default: begin
        val   = pc_data;
        shamt = SH_W'(int'(slot) * 32);
        last  = (int'(slot) == LAST32);
      end
    endcase
    merged = acc | ({{(WORD_W-PIX_W){1'b0}}, val} << shamt);
  end

  assign pc_ready = run && (!out_valid || out_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc       <= '0;
      slot      <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_eol   <= 1'b0;
    end else if (!run) begin
      acc       <= '0;
      slot      <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_eol   <= 1'b0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (pc_valid && pc_ready) begin
        if (last || pc_eol) begin
          out_data  <= merged;
          out_eol   <= pc_eol;
          out_valid <= 1'b1;
          acc       <= '0;
          slot      <= '0;
        end else begin
          acc  <= merged;
          slot <= slot + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/cam_pixpack.sv
module cam_pixpack
  import cam_pixpack_pkg::*;
#(
  parameter int WORD_W = 128
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_pix_run,
  input  logic              cfg_enable,
  input  logic [5:0]        cfg_dtype,
  input  logic [1:0]        cfg_csize,
  input  logic [1:0]        cfg_yuv_mode,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic              in_eol,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              out_eol
);

  logic             pc_valid;
  logic             pc_ready;
  logic [PIX_W-1:0] pc_data;
  logic             pc_eol;

  cam_unpack u_unpack (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (cfg_pix_run),
    .en       (cfg_enable),
    .dt       (cfg_dtype),
    .mode     (cfg_yuv_mode),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (in_data),
    .in_eol   (in_eol),
    .pc_valid (pc_valid),
    .pc_ready (pc_ready),
    .pc_data  (pc_data),
    .pc_eol   (pc_eol)
  );

  cam_pack #(.WORD_W(WORD_W)) u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (cfg_pix_run),
    .csize     (cfg_csize),
    .pc_valid  (pc_valid),
    .pc_ready  (pc_ready),
    .pc_data   (pc_data),
    .pc_eol    (pc_eol),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_eol   (out_eol)
  );

endmodule

// File: rtl/cam_pixpack_chk.sv
module cam_pixpack_chk
  import cam_pixpack_pkg::*;
#(
  parameter int WORD_W = 128
)(
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_pix_run,
  input logic              cfg_enable,
  input logic [5:0]        cfg_dtype,
  input logic [1:0]        cfg_csize,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_data,
  input logic              out_eol
);

  localparam logic [WORD_W-1:0] RAW10_PAD = {(WORD_W/16){16'hFC00}};
  localparam logic [WORD_W-1:0] B8_IN_32  = {(WORD_W/32){32'hFFFF_FF00}};

  a_r1_reset_clears_out: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_pix_run |=> !out_valid);

  a_r1_reset_blocks_in: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_pix_run |-> !in_ready);

  a_r2_enable_gates_in: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |-> !in_ready);

  a_r12_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && cfg_pix_run) |=>
      (out_valid && $stable(out_data) && $stable(out_eol)));

  a_r4_raw10_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cfg_dtype == DT_RAW10 && cfg_csize == 2'd1) |->
      ((out_data & RAW10_PAD) == '0));

  a_r4_byte_in_wide_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cfg_dtype == DT_RAW8 && cfg_csize == 2'd2) |->
      ((out_data & B8_IN_32) == '0));

endmodule

bind cam_pixpack cam_pixpack_chk #(.WORD_W(WORD_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_pix_run (cfg_pix_run),
  .cfg_enable  (cfg_enable),
  .cfg_dtype   (cfg_dtype),
  .cfg_csize   (cfg_csize),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_data    (out_data),
  .out_eol     (out_eol)
);

// File: tb/cam_pixpack_tb.sv
`timescale 1ns/1ps
module cam_pixpack_tb;

  localparam int W = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_pix_run = 1'b0, cfg_enable = 1'b0;
  logic [5:0] cfg_dtype = 6'h2A;
  logic [1:0] cfg_csize = 2'd0, cfg_yuv_mode = 2'd3;
  logic in_valid = 1'b0, in_eol = 1'b0;
  logic [7:0] in_data = 8'd0;
  logic in_ready, out_valid, out_eol;
  logic out_ready = 1'b1;
  logic [W-1:0] out_data;

  always #10 clk = ~clk;

  cam_pixpack #(.WORD_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_pix_run(cfg_pix_run), .cfg_enable(cfg_enable),
    .cfg_dtype(cfg_dtype), .cfg_csize(cfg_csize), .cfg_yuv_mode(cfg_yuv_mode),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_eol(in_eol),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_eol(out_eol)
  );

  int n_chk = 0, n_fail = 0;

  typedef struct packed {
    logic [5:0] dt; logic [1:0] cs; logic [1:0] md;
    logic [7:0] nb; logic bp; logic [7:0] seed; logic [3:0] req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VT [NV] = '{
    '{6'h2A, 2'd0, 2'd3, 8'd32, 1'b0, 8'd1,  4'd5},  // R5 raw8
    '{6'h1E, 2'd0, 2'd3, 8'd32, 1'b0, 8'd2,  4'd9},  // R9 mode 3
    '{6'h1E, 2'd0, 2'd2, 8'd16, 1'b0, 8'd3,  4'd9},  // R9 mode 2
    '{6'h1E, 2'd0, 2'd1, 8'd16, 1'b0, 8'd4,  4'd9},  // R9 mode 1
    '{6'h1E, 2'd0, 2'd0, 8'd32, 1'b1, 8'd5,  4'd9},  // R9 mode 0 with stalls
    '{6'h2B, 2'd1, 2'd0, 8'd20, 1'b0, 8'd6,  4'd6},  // R6 raw10, R4 zero fill
    '{6'h22, 2'd1, 2'd2, 8'd32, 1'b0, 8'd7,  4'd7},  // R7
    '{6'h24, 2'd2, 2'd1, 8'd24, 1'b0, 8'd8,  4'd8},  // R8
    '{6'h2A, 2'd1, 2'd0, 8'd16, 1'b0, 8'd9,  4'd4},  // R4 byte in 16-bit, R3
    '{6'h2A, 2'd2, 2'd0, 8'd8,  1'b0, 8'd10, 4'd3},  // R3 32-bit container
    '{6'h2A, 2'd0, 2'd0, 8'd16, 1'b0, 8'd11, 4'd10}, // R10 mode ignored raw8
    '{6'h22, 2'd1, 2'd0, 8'd16, 1'b0, 8'd12, 4'd10}, // R10 mode ignored rgb565
    '{6'h12, 2'd0, 2'd1, 8'd16, 1'b0, 8'd13, 4'd5},  // R5 unlisted type
    '{6'h2A, 2'd0, 2'd3, 8'd20, 1'b0, 8'd14, 4'd11}, // R11 partial word
    '{6'h2B, 2'd1, 2'd3, 8'd7,  1'b0, 8'd15, 4'd11}, // R11 partial group
    '{6'h2B, 2'd1, 2'd3, 8'd20, 1'b1, 8'd16, 4'd12}, // R12 back-pressure
    '{6'h24, 2'd3, 2'd2, 8'd12, 1'b0, 8'd17, 4'd3},  // R3 code 3
    '{6'h24, 2'd2, 2'd0, 8'd24, 1'b1, 8'd18, 4'd12}  // R12 back-pressure
  };

  logic [7:0]   bq [0:255];
  logic [W-1:0] exp_w [0:63];
  logic [W-1:0] got_w [0:63];
  logic         got_e [0:63];
  int ne, ng;
  logic bp_on = 1'b0;
  int cyc = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (out_valid && out_ready) begin
      if (ng < 64) begin got_w[ng] = out_data; got_e[ng] = out_eol; end
      ng = ng + 1;
    end
  end

  always @(negedge clk) out_ready <= bp_on ? ((cyc % 3) != 0) : 1'b1;

  function automatic logic [31:0] ref_pix(input logic [5:0] dt, input logic [1:0] md,
                                          input int b, input int k);
    int s;
    case (dt)
      6'h1E: begin
        case (md)
          2'd3: s = k;
          2'd2: s = (k == 0) ? 2 : (k == 2) ? 0 : k;
          2'd1: s = (k == 0) ? 1 : (k == 1) ? 0 : (k == 2) ? 3 : 2;
          default: s = (k == 3) ? 0 : k + 1;
        endcase
        return {24'd0, bq[b+s]};
      end
      6'h2B: return {22'd0, bq[b+k], 2'((bq[b+4] >> (2*k)) & 8'h3)};
      6'h22: return {16'd0, bq[b+1], bq[b]};
      6'h24: return {8'd0, bq[b+2], bq[b+1], bq[b]};
      default: return {24'd0, bq[b]};
    endcase
  endfunction

  task automatic build_exp(input vec_t v);
    int gl, np, cw, per, npx, ngrp;
    logic [31:0] p;
    case (v.dt)
      6'h1E: begin gl = 4; np = 4; end
      6'h2B: begin gl = 5; np = 4; end
      6'h22: begin gl = 2; np = 1; end
      6'h24: begin gl = 3; np = 1; end
      default: begin gl = 1; np = 1; end
    endcase
    cw  = (v.cs == 2'd0) ? 8 : (v.cs == 2'd1) ? 16 : 32;
    per = W / cw;
    for (int i = 0; i < 256; i++) bq[i] = (i < int'(v.nb)) ? 8'(v.seed * 37 + i * 13 + (i >> 2) + 5) : 8'd0;
    for (int i = 0; i < 64; i++) exp_w[i] = '0;
    ngrp = (int'(v.nb) + gl - 1) / gl;
    npx = 0;
    for (int g = 0; g < ngrp; g++)
      for (int k = 0; k < np; k++) begin
        p = ref_pix(v.dt, v.md, g * gl, k);
        for (int b = 0; b < cw; b++) exp_w[npx / per][(npx % per) * cw + b] = p[b];
        npx++;
      end
    ne = (npx + per - 1) / per;
  endtask

  task automatic send_bytes(input int nb, input logic with_eol, input logic gaps);
    for (int i = 0; i < nb; i++) begin
      @(negedge clk);
      if (gaps && (i % 3 == 2)) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1; in_data = bq[i]; in_eol = with_eol && (i == nb - 1);
      do @(posedge clk); while (!in_ready);
    end
    @(negedge clk);
    in_valid = 1'b0; in_eol = 1'b0;
  endtask

  task automatic check(input bit ok, input int req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  task automatic run_vec(input vec_t v);
    @(negedge clk);
    cfg_dtype = v.dt; cfg_csize = v.cs; cfg_yuv_mode = v.md; bp_on = v.bp;
    build_exp(v);
    ng = 0;
    send_bytes(int'(v.nb), 1'b1, v.bp);
    for (int t = 0; t < 600 && ng < ne; t++) @(negedge clk);
    repeat (6) @(negedge clk);
    check(ng == ne, int'(v.req), "word count", W'(ng), W'(ne));
    for (int i = 0; i < ne && i < ng && i < 64; i++) begin
      check(got_w[i] === exp_w[i], int'(v.req), "word data", got_w[i], exp_w[i]);
      check(got_e[i] === (i == ne - 1), int'(v.req), "eol flag", W'(got_e[i]), W'(i == ne - 1));
    end
    bp_on = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk + 1, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!out_valid && !in_ready, 1, "reset state", W'({out_valid, in_ready}), '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    in_valid = 1'b1; cfg_enable = 1'b1;
    @(negedge clk);
    check(!in_ready, 1, "run low blocks input", W'(in_ready), '0);
    // R2: enable low gates input
    cfg_pix_run = 1'b1; cfg_enable = 1'b0;
    repeat (4) @(negedge clk);
    check(!in_ready && !out_valid, 2, "enable low", W'({in_ready, out_valid}), '0);
    in_valid = 1'b0; cfg_enable = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) run_vec(VT[v]);

    // R1: pixel reset mid-line discards partial data
    cfg_dtype = 6'h2A; cfg_csize = 2'd0;
    for (int i = 0; i < 6; i++) bq[i] = 8'hA0 + 8'(i);
    send_bytes(6, 1'b0, 1'b0);
    cfg_pix_run = 1'b0;
    repeat (2) @(negedge clk);
    check(!out_valid && !in_ready, 1, "pix reset held", W'({out_valid, in_ready}), '0);
    cfg_pix_run = 1'b1;
    run_vec('{6'h2A, 2'd0, 2'd3, 8'd16, 1'b0, 8'd40, 4'd1});

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule